// File: doc/BRIEF.md
# SPI Mode Command Validator

This block sits behind the SPI frame decoder of a power-management companion chip. Each decoded write (an address and an 8-bit data field) passes through it. The block owns the chip's operating-mode state machine, with the modes Init, Normal, Stop, Sleep and Restart. It judges every write against the present mode and the configured wake sources. A write is then applied in full, applied with some bits held back, or refused. A refused write raises a sticky failure flag. Some refused mode requests also force the machine into a fallback mode instead of dropping the request.

Accepted writes leave the block as a one-cycle, one-hot register write enable with the write value, which may be corrected. Downstream register banks, the watchdog and the regulators consume these enables. The command input is a valid/ready stream. `cmd_ready` is held high at all times, so a command is taken in every cycle where `cmd_valid` is high. The block never applies back-pressure and keeps no queue. All outputs are registered and reflect a command one clock after the cycle that carries it.

Top module: `spi_mode_guard`

## Requirements
- R1: Reset gives mode code 0 (Init), failure flag low, no write enable, interrupt low. Mode codes are Init=0, Normal=1, Stop=2, Sleep=3, Restart=4. `cmd_ready` is always 1.
- R2: A write to address 0 (mode control) carries the request in data[1:0]: 0=Normal, 1=Stop, 2=Sleep, 3=soft reset. In Init, a Stop or Sleep request sets the failure flag, moves to Normal and is still written.
- R3: In Stop, a Sleep request sets the failure flag, moves to Restart and issues no write enable.
- R4: In Normal, a Sleep request goes to Sleep when the wake-enable register (address 3) is nonzero. When that register is zero, the request sets the failure flag and moves to Restart, and the mode-control write is still issued with its data unchanged.
- R5: In Normal, a Stop request enters Stop without failure, even when the wake-enable register is zero.
- R6: In Stop, only these writes are accepted: watchdog (address 1), status clear (address 4), and a mode-control write requesting Normal or soft reset. Any other mapped write, including a Stop request, issues no enable and sets the failure flag.
- R7: A Normal request made from Stop writes data[7:2] equal to the value last written to those bits. Any new values in those bits are discarded.
- R8: A watchdog write is accepted only when the XOR of its 8 data bits is 1. Otherwise it issues no enable and sets the failure flag.
- R9: The failure flag stays set until a status-clear write (address 4) with data[0]=1 is accepted. It is then low in the next cycle.
- R10: Entering Stop while `wake_pending` is high gives a one-cycle `wake_irq` pulse and does not set the failure flag.
- R11: A supply write (address 2) cannot clear bit 0 once that bit is set. The written value keeps bit 0 at 1 and applies the other bits as given.
- R12: Writes to addresses at or above NREG (8) issue no enable, leave the failure flag unchanged and leave the mode unchanged.
- R13: Restart moves to Init on the next clock. Sleep moves to Restart when `wake_event` is high. Commands in Sleep and Restart are ignored and never set the failure flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Decoded write command present |
| cmd_ready | output | 1 | Always high; the block takes every command |
| cmd_addr | input | 5 | Register address of the command |
| cmd_data | input | 8 | Data field of the command |
| wake_pending | input | 1 | Wake status bits are still uncleared |
| wake_event | input | 1 | Wake-up seen while sleeping |
| mode | output | 3 | Current operating mode |
| reg_we | output | 8 | One-hot write enable per register, one cycle |
| reg_wdata | output | 8 | Value to write, after corrections |
| fail_flag | output | 1 | Sticky command failure flag |
| wake_irq | output | 1 | Pulse on Stop entry with pending wake status |

## Verification
The bench goes after the redirected mode requests. Sleep from Stop must land in Restart, and a design that simply dropped the request would stay in Stop. Stop or Sleep from Init must land in Normal, and a design that got this wrong would stay in Init. A Sleep request with no wake sources must still write the register, and a design that skipped this would lose the other bits.

Other corner cases are the narrow accept list in Stop and the discarded upper bits on the Stop-to-Normal write. A design that got the accept list wrong would let configuration writes through in Stop. A design that got the upper bits wrong would leak new values into those bits. The sticky load-share bit and the watchdog parity are also checked: either one implemented loosely would change the written value or the flag.

Random command streams with random wake inputs cross every mode with every address, including unmapped ones. These streams show whether the flag ever sets or clears on the wrong command.

// File: rtl/smg_pkg.sv
package smg_pkg;
  typedef enum logic [2:0] {
    M_INIT    = 3'd0,
    M_NORMAL  = 3'd1,
    M_STOP    = 3'd2,
    M_SLEEP   = 3'd3,
    M_RESTART = 3'd4
  } mode_e;

  localparam logic [1:0] REQ_NORMAL  = 2'd0;
  localparam logic [1:0] REQ_STOP    = 2'd1;
  localparam logic [1:0] REQ_SLEEP   = 2'd2;
  localparam logic [1:0] REQ_SOFTRST = 2'd3;

  localparam int IDX_MODE   = 0;
  localparam int IDX_WDOG   = 1;
  localparam int IDX_SUPPLY = 2;
  localparam int IDX_WAKE   = 3;
  localparam int IDX_STAT   = 4;
endpackage

// File: rtl/smg_decode.sv
module smg_decode #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int NREG   = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [NREG-1:0]   sel,
  output logic              parity_odd
);
  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i));
  end

  assign parity_odd = ^data;
endmodule

// File: rtl/smg_policy.sv
module smg_policy
  import smg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NREG   = 8
) (
  input  logic              cmd_valid,
  input  mode_e             mode,
  input  logic [NREG-1:0]   sel,
  input  logic [DATA_W-1:0] data,
  input  logic              parity_odd,
  input  logic              wake_any,
  input  logic [DATA_W-3:0] mode_hi,
  input  logic              supply_ls,
  input  logic              wake_pending,
  input  logic              wake_event,
  output mode_e             next_mode,
  output logic              set_fail,
  output logic              clr_fail,
  output logic              irq,
  output logic [NREG-1:0]   we,
  output logic [DATA_W-1:0] wdata
);
  logic active, in_stop, in_map;

  assign active  = (mode == M_INIT) || (mode == M_NORMAL) || (mode == M_STOP);
  assign in_stop = (mode == M_STOP);
  assign in_map  = |sel;

  always_comb begin
    next_mode = mode;
    set_fail  = 1'b0;
    clr_fail  = 1'b0;
    irq       = 1'b0;
    we        = '0;
    wdata     = data;
    if (mode == M_RESTART) begin
      next_mode = M_INIT;
    end else if (mode == M_SLEEP) begin
      if (wake_event) next_mode = M_RESTART;
    end else if (cmd_valid && active) begin
      if (sel[IDX_MODE]) begin
        case (data[1:0])
          REQ_NORMAL: begin
            we[IDX_MODE] = 1'b1;
            next_mode    = M_NORMAL;
            if (in_stop) wdata = {mode_hi, data[1:0]};
          end
          REQ_STOP: begin
            if (mode == M_INIT) begin
              we[IDX_MODE] = 1'b1;
              set_fail     = 1'b1;
              next_mode    = M_NORMAL;
            end else if (mode == M_NORMAL) begin
              we[IDX_MODE] = 1'b1;
              next_mode    = M_STOP;
              irq          = wake_pending;
            end else begin
              set_fail = 1'b1;
            end
          end
          REQ_SLEEP: begin
            if (mode == M_INIT) begin
              we[IDX_MODE] = 1'b1;
              set_fail     = 1'b1;
              next_mode    = M_NORMAL;
            end else if (mode == M_NORMAL) begin
              we[IDX_MODE] = 1'b1;
              if (wake_any) begin
                next_mode = M_SLEEP;
              end else begin
                set_fail  = 1'b1;
                next_mode = M_RESTART;
              end
            end else begin
              set_fail  = 1'b1;
              next_mode = M_RESTART;
            end
          end
          default: begin
            we[IDX_MODE] = 1'b1;
            next_mode    = M_RESTART;
          end
        endcase
      end else if (sel[IDX_WDOG]) begin
        if (parity_odd) we[IDX_WDOG] = 1'b1;
        else            set_fail     = 1'b1;
      end else if (sel[IDX_STAT]) begin
        we[IDX_STAT] = 1'b1;
        clr_fail     = data[0];
      end else if (in_map) begin
        if (in_stop) begin
          set_fail = 1'b1;
        end else begin
          we = sel;
          if (sel[IDX_SUPPLY]) wdata[0] = data[0] | supply_ls;
        end
      end
    end
  end
endmodule

// File: rtl/smg_state.sv
module smg_state
  import smg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NREG   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [NREG-1:0]   sel,
  input  logic [DATA_W-1:0] data,
  input  mode_e             next_mode,
  input  logic              set_fail,
  input  logic              clr_fail,
  input  logic              irq,
  input  logic [NREG-1:0]   we,
  input  logic [DATA_W-1:0] wdata,
  output mode_e             mode_q,
  output logic              fail_q,
  output logic [NREG-1:0]   we_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              irq_q,
  output logic              wake_any,
  output logic [DATA_W-3:0] mode_hi,
  output logic              supply_ls
);
  logic [DATA_W-1:0] wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_INIT;
      fail_q    <= 1'b0;
      we_q      <= '0;
      wdata_q   <= '0;
      irq_q     <= 1'b0;
      mode_hi   <= '0;
      supply_ls <= 1'b0;
      wake_q    <= '0;
    end else begin
      mode_q  <= next_mode;
      if (set_fail)      fail_q <= 1'b1;
      else if (clr_fail) fail_q <= 1'b0;
      we_q    <= we;
      wdata_q <= wdata;
      irq_q   <= irq;
      if (we[IDX_MODE])   mode_hi   <= wdata[DATA_W-1:2];
      if (we[IDX_SUPPLY]) supply_ls <= wdata[0];
      if (we[IDX_WAKE])   wake_q    <= wdata;
    end
  end

  assign wake_any = |wake_q;

  // R3: Stop to Sleep is redirected to Restart with nothing written
  a_r3_stop_sleep_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && mode_q == M_STOP && sel[IDX_MODE] && data[1:0] == REQ_SLEEP)
    |=> (mode_q == M_RESTART && fail_q && we_q == '0));

  // R2: Init refuses low-power requests and lands in Normal
  a_r2_init_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && mode_q == M_INIT && sel[IDX_MODE] && (data[1] ^ data[0]))
    |=> (mode_q == M_NORMAL && fail_q));

  // R9: the flag only drops on an explicit clear
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !(cmd_valid && sel[IDX_STAT] && data[0])) |=> fail_q);

  // R12: unmapped addresses are silent
  a_r12_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && sel == '0) |=> (we_q == '0 && fail_q == $past(fail_q)));

  // R13: Restart always falls through to Init
  a_r13_restart_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RESTART) |=> (mode_q == M_INIT));

  // R10: the wake interrupt only accompanies Stop entry
  a_r10_irq_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (mode_q == M_STOP && $past(mode_q) == M_NORMAL));

  // R6: at most one register enable per cycle
  a_r6_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_q));
endmodule

// File: rtl/spi_mode_guard.sv
module spi_mode_guard #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int NREG   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              wake_pending,
  input  logic              wake_event,
  output logic [2:0]        mode,
  output logic [NREG-1:0]   reg_we,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              fail_flag,
  output logic              wake_irq
);
  import smg_pkg::*;

  localparam int HI_W = DATA_W - 2;

  logic [NREG-1:0]   sel, we;
  logic              parity_odd, wake_any, supply_ls;
  logic              set_fail, clr_fail, irq;
  logic [HI_W-1:0]   mode_hi;
  logic [DATA_W-1:0] wdata;
  mode_e             mode_q, next_mode;

  assign cmd_ready = 1'b1;
  assign mode      = mode_q;

  smg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG)) u_decode (
    .addr(cmd_addr), .data(cmd_data), .sel(sel), .parity_odd(parity_odd)
  );

  smg_policy #(.DATA_W(DATA_W), .NREG(NREG)) u_policy (
    .cmd_valid(cmd_valid), .mode(mode_q), .sel(sel), .data(cmd_data),
    .parity_odd(parity_odd), .wake_any(wake_any), .mode_hi(mode_hi),
    .supply_ls(supply_ls), .wake_pending(wake_pending), .wake_event(wake_event),
    .next_mode(next_mode), .set_fail(set_fail), .clr_fail(clr_fail),
    .irq(irq), .we(we), .wdata(wdata)
  );

  smg_state #(.DATA_W(DATA_W), .NREG(NREG)) u_state (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .sel(sel), .data(cmd_data),
    .next_mode(next_mode), .set_fail(set_fail), .clr_fail(clr_fail), .irq(irq),
    .we(we), .wdata(wdata), .mode_q(mode_q), .fail_q(fail_flag), .we_q(reg_we),
    .wdata_q(reg_wdata), .irq_q(wake_irq), .wake_any(wake_any),
    .mode_hi(mode_hi), .supply_ls(supply_ls)
  );
endmodule

// File: tb/spi_mode_guard_tb.sv
`timescale 1ns/1ps
module spi_mode_guard_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [4:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic       wake_pending = 1'b0;
  logic       wake_event = 1'b0;
  logic [2:0] mode;
  logic [7:0] reg_we, reg_wdata;
  logic       fail_flag, wake_irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  // reference model state
  int         m_mode = 0;
  logic       m_fail = 1'b0;
  logic [5:0] m_hi = '0;
  logic       m_ls = 1'b0;
  logic [7:0] m_wake = '0;
  logic [7:0] e_we;
  logic [7:0] e_wdata;
  logic       e_irq;

  spi_mode_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wake_pending(wake_pending),
    .wake_event(wake_event), .mode(mode), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .fail_flag(fail_flag), .wake_irq(wake_irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(input logic v, input logic [4:0] a, input logic [7:0] d,
                            input logic wp, input logic wev);
    int nm;
    logic sf, cf;
    nm = m_mode; sf = 0; cf = 0;
    e_we = '0; e_wdata = d; e_irq = 0;
    if (m_mode == 4) nm = 0;
    else if (m_mode == 3) begin
      if (wev) nm = 4;
    end else if (v) begin
      if (a == 0) begin
        case (d[1:0])
          2'd0: begin e_we = 8'h01; nm = 1; if (m_mode == 2) e_wdata = {m_hi, 2'b00}; end
          2'd1: begin
            if (m_mode == 0) begin e_we = 8'h01; sf = 1; nm = 1; end
            else if (m_mode == 1) begin e_we = 8'h01; nm = 2; e_irq = wp; end
            else sf = 1;
          end
          2'd2: begin
            if (m_mode == 0) begin e_we = 8'h01; sf = 1; nm = 1; end
            else if (m_mode == 1) begin
              e_we = 8'h01;
              if (m_wake != 0) nm = 3; else begin sf = 1; nm = 4; end
            end else begin sf = 1; nm = 4; end
          end
          default: begin e_we = 8'h01; nm = 4; end
        endcase
      end else if (a == 1) begin
        if (^d) e_we = 8'h02; else sf = 1;
      end else if (a == 4) begin
        e_we = 8'h10; cf = d[0];
      end else if (a < 8) begin
        if (m_mode == 2) sf = 1;
        else begin
          e_we = 8'(1 << a);
          if (a == 2) e_wdata[0] = d[0] | m_ls;
        end
      end
    end
    if (e_we[0]) m_hi = e_wdata[7:2];
    if (e_we[2]) m_ls = e_wdata[0];
    if (e_we[3]) m_wake = e_wdata;
    if (sf) m_fail = 1; else if (cf) m_fail = 0;
    m_mode = nm;
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(input logic v, input logic [4:0] a, input logic [7:0] d,
                      input logic wp, input logic wev, input string tag);
    cmd_valid = v; cmd_addr = a; cmd_data = d; wake_pending = wp; wake_event = wev;
    model_step(v, a, d, wp, wev);
    @(posedge clk); #3;
    cmp(tag, "mode", int'(mode), m_mode);
    cmp(tag, "fail_flag", int'(fail_flag), int'(m_fail));
    cmp(tag, "reg_we", int'(reg_we), int'(e_we));
    cmp(tag, "wake_irq", int'(wake_irq), int'(e_irq));
    if (e_we != 0) cmp(tag, "reg_wdata", int'(reg_wdata), int'(e_wdata));
    cmp("R1", "cmd_ready", int'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic idle(input string tag);
    step(1'b0, 5'd0, 8'h00, 1'b0, 1'b0, tag);
  endtask

  function automatic string rtag(input logic [4:0] a);
    if (a >= 8) return "R12";
    if (m_mode >= 3) return "R13";
    if (m_mode == 2) return "R6";
    case (a)
      5'd0: return "R4";
      5'd1: return "R8";
      5'd2: return "R11";
      5'd4: return "R9";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [4:0] ra;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1", "mode", int'(mode), 0);
    cmp("R1", "fail_flag", int'(fail_flag), 0);
    cmp("R1", "reg_we", int'(reg_we), 0);
    cmp("R1", "wake_irq", int'(wake_irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    step(1, 0, 8'h01, 0, 0, "R2");      // Stop from Init -> Normal, fail
    step(1, 4, 8'h01, 0, 0, "R9");      // clear
    step(1, 3, 8'h00, 0, 0, "R5");      // no wake sources
    step(1, 0, 8'h55, 1, 0, "R10");     // Stop entry with pending wake
    cmp("R5", "fail_flag", int'(fail_flag), 0);
    step(1, 3, 8'h0F, 0, 0, "R6");      // wake write refused in Stop
    step(1, 4, 8'h01, 0, 0, "R9");
    step(1, 5, 8'hAA, 0, 0, "R6");      // config refused in Stop
    step(1, 1, 8'h01, 0, 0, "R8");      // good parity accepted in Stop
    step(1, 0, 8'h01, 0, 0, "R6");      // Stop request in Stop refused
    step(1, 0, 8'hFC, 0, 0, "R7");      // back to Normal, upper bits kept
    step(1, 0, 8'h01, 0, 0, "R5");
    step(1, 0, 8'h02, 0, 0, "R3");      // Stop -> Sleep redirected
    idle("R13");
    step(1, 4, 8'h01, 0, 0, "R9");
    step(1, 0, 8'h00, 0, 0, "R2");
    step(1, 0, 8'h0E, 0, 0, "R4");      // Sleep with no wake sources
    idle("R13");
    step(1, 0, 8'h00, 0, 0, "R4");
    step(1, 3, 8'h04, 0, 0, "R4");
    step(1, 0, 8'h02, 0, 0, "R4");      // Sleep accepted
    step(1, 4, 8'h01, 0, 0, "R13");     // ignored in Sleep, flag stays
    step(1, 0, 8'h00, 0, 1, "R13");     // wake -> Restart
    idle("R13");
    step(1, 0, 8'h00, 0, 0, "R2");
    step(1, 2, 8'h01, 0, 0, "R11");
    step(1, 2, 8'h40, 0, 0, "R11");     // bit 0 stays set
    step(1, 1, 8'h03, 0, 0, "R8");      // even parity refused
    step(1, 31, 8'hFF, 0, 0, "R12");
    step(1, 8, 8'h00, 0, 0, "R12");

    for (int i = 0; i < 3000; i++) begin
      ra = ($urandom % 5 != 0) ? 5'($urandom % 8) : 5'($urandom);
      step(($urandom % 10) < 7, ra, 8'($urandom), $urandom % 2 == 0,
           $urandom % 5 == 0, rtag(ra));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule